// File: doc/BRIEF.md
# Associative Module Remap Table

This block steers accesses inside one memory bank. The bank holds 2^q working modules and r spare modules. Each physical module has one entry in a small content-addressable table. An entry stores the module number that the physical module currently serves, plus a flag that marks the entry as live. A request carries a q-bit module number. Every live entry compares its stored number against that field at the same time. The entry that matches raises its bit in a registered, one-hot select vector, and that bit enables the physical module directly.

After reset the table is the identity map: entry i serves module i, and the spare entries are dead. When a physical module is reported faulty, its entry is killed and the number it served moves into the lowest spare entry not yet used. Later requests for that number then land on the spare, and the requester does not see the change. Once the spares are used up, a faulty module can only be killed. A request for a number that no live entry holds raises an error strobe in place of a select.

Top module: `module_remap_cam`

## Requirements
- R1: After reset, a request for module m (0 ≤ m < 2^q) selects physical module m. No spare entry (index 2^q and up) is ever selected while no fault has been reported.
- R2: The select vector has 2^q+r bits, bit i enabling physical module i. It and `selValid` appear on the clock edge after the cycle in which `lookupValid` is high, and both are zero after a cycle without a request.
- R3: A fault report on a live working entry, while a spare remains, kills that entry and copies its module number into the lowest unused spare entry. Later requests for that number select the spare.
- R4: Spares are handed out in ascending index order: 2^q first, then 2^q+1, and so on. Each spare is used at most once.
- R5: A fault report on a live spare entry that is serving a relocated module moves that module number to the next unused spare.
- R6: A fault report on an entry that is already dead, or on an index of 2^q+r or more, has no effect on the table and uses no spare.
- R7: With no spare left, a fault report kills the entry without replacement. A request for a number that no live entry holds then gives an all-zero select with `refError` high for one cycle, while `selValid` is still high.
- R8: When a request and a fault report arrive in the same cycle, the request is resolved against the table as it stood before that report.
- R9: At most one select bit is ever high, and no more than 2^q entries are live at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | A request is present this cycle |
| lookupModule | input | q | Module number field of the request |
| faultValid | input | 1 | A fault report is present this cycle |
| faultIndex | input | clog2(2^q+r) | Physical module reported faulty |
| selValid | output | 1 | The select/error result of last cycle's request is present |
| moduleSelect | output | 2^q+r | One-hot physical module enable |
| refError | output | 1 | Request hit a module that has no live entry |

## Verification
The bench first walks the identity map. It then retires a working module in the same cycle as a request for it, so a design that resolves the request against the updated table moves the select to the spare one cycle early. It repeats reports on dead entries and on an index past the table, so a design that spends a spare on them puts the next relocation on the wrong index. It retires a spare that holds a relocated module and finally drains the spares. A design that keeps a killed entry matching, or that stays silent on an unservable request, then shows a stale select or a missing error.

// File: rtl/remap_pkg.sv
package remap_pkg;
  // strobes from the control to the table datapath
  typedef struct packed {
    logic retire;    // kill the reported entry
    logic relocate;  // copy its module number into the next spare
  } remapStrobe_t;
endpackage

// File: rtl/remap_cam_ctrl.sv
module remap_cam_ctrl
  import remap_pkg::*;
#(
  parameter int MOD_BITS = 2,
  parameter int SPARES   = 2,
  localparam int BASE    = 1 << MOD_BITS,
  localparam int WORDS   = BASE + SPARES,
  localparam int IDXW    = $clog2(WORDS),
  localparam int CNTW    = $clog2(SPARES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             faultValid,
  input  logic [IDXW-1:0]  faultIndex,
  input  logic [WORDS-1:0] validVec,
  output remapStrobe_t     strobe,
  output logic [IDXW-1:0]  victim,
  output logic [IDXW-1:0]  spareSlot
);
  logic [CNTW-1:0] freeCount;
  logic inRange;
  logic hitLive;

  assign inRange   = ({1'b0, faultIndex} < (IDXW+1)'(WORDS));
  assign hitLive   = faultValid && inRange && validVec[faultIndex];
  assign victim    = faultIndex;
  // lowest unused spare: spares are consumed strictly in ascending order
  assign spareSlot = IDXW'(BASE) + IDXW'(SPARES) - IDXW'(freeCount);

  always_comb begin
    strobe.retire   = hitLive;
    strobe.relocate = hitLive && (freeCount != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) freeCount <= CNTW'(SPARES);
    else if (strobe.relocate) freeCount <= freeCount - 1'b1;
  end

  // R4: the spare handed out must still be unused (dead) in the table
  assert_spare_unused_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.relocate |-> !validVec[spareSlot]);
  // R4: the free-spare count never grows
  assert_free_monotonic_R4: assert property (@(posedge clk) disable iff (!rstN)
    freeCount <= $past(freeCount));
endmodule

// File: rtl/remap_cam_dp.sv
module remap_cam_dp
  import remap_pkg::*;
#(
  parameter int MOD_BITS = 2,
  parameter int SPARES   = 2,
  localparam int BASE    = 1 << MOD_BITS,
  localparam int WORDS   = BASE + SPARES,
  localparam int IDXW    = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lookupValid,
  input  logic [MOD_BITS-1:0] lookupModule,
  input  remapStrobe_t        strobe,
  input  logic [IDXW-1:0]     victim,
  input  logic [IDXW-1:0]     spareSlot,
  output logic [WORDS-1:0]    validVec,
  output logic                selValid,
  output logic [WORDS-1:0]    moduleSelect,
  output logic                refError
);
  logic [MOD_BITS-1:0] storedMod [WORDS];
  logic [WORDS-1:0]    hitVec;

  // parallel compare, one comparator per entry
  for (genvar i = 0; i < WORDS; i++) begin : g_cmp
    assign hitVec[i] = validVec[i] && (storedMod[i] == lookupModule);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) begin
        storedMod[i] <= (i < BASE) ? MOD_BITS'(i) : '0;
        validVec[i]  <= (i < BASE);
      end
    end else begin
      if (strobe.retire) validVec[victim] <= 1'b0;
      if (strobe.relocate) begin
        storedMod[spareSlot] <= storedMod[victim];
        validVec[spareSlot]  <= 1'b1;
      end
    end
  end

  // match register: resolved against the table before this cycle's update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selValid     <= 1'b0;
      moduleSelect <= '0;
      refError     <= 1'b0;
    end else begin
      selValid     <= lookupValid;
      moduleSelect <= lookupValid ? hitVec : '0;
      refError     <= lookupValid && (hitVec == '0);
    end
  end

  assert_onehot_select_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(moduleSelect));
  assert_live_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones(validVec) <= BASE);
  assert_retire_kills_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.retire |=> !validVec[$past(victim)]);
  assert_relocate_live_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.relocate |=> validVec[$past(spareSlot)]);
  assert_error_no_select_R7: assert property (@(posedge clk) disable iff (!rstN)
    refError |-> (moduleSelect == '0) && selValid);
endmodule

// File: rtl/module_remap_cam.sv
module module_remap_cam
  import remap_pkg::*;
#(
  parameter int MOD_BITS = 2,
  parameter int SPARES   = 2,
  localparam int BASE    = 1 << MOD_BITS,
  localparam int WORDS   = BASE + SPARES,
  localparam int IDXW    = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lookupValid,
  input  logic [MOD_BITS-1:0] lookupModule,
  input  logic                faultValid,
  input  logic [IDXW-1:0]     faultIndex,
  output logic                selValid,
  output logic [WORDS-1:0]    moduleSelect,
  output logic                refError
);
  remapStrobe_t     strobe;
  logic [IDXW-1:0]  victim;
  logic [IDXW-1:0]  spareSlot;
  logic [WORDS-1:0] validVec;

  remap_cam_ctrl #(.MOD_BITS(MOD_BITS), .SPARES(SPARES)) u_ctrl (
    .clk(clk), .rstN(rstN), .faultValid(faultValid), .faultIndex(faultIndex),
    .validVec(validVec), .strobe(strobe), .victim(victim), .spareSlot(spareSlot));

  remap_cam_dp #(.MOD_BITS(MOD_BITS), .SPARES(SPARES)) u_dp (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupModule(lookupModule),
    .strobe(strobe), .victim(victim), .spareSlot(spareSlot), .validVec(validVec),
    .selValid(selValid), .moduleSelect(moduleSelect), .refError(refError));
endmodule

// File: tb/sim_module_remap_cam.sv
`timescale 1ns/1ps
module sim_module_remap_cam;
  localparam int Q = 2;
  localparam int R = 2;
  localparam int B = 1 << Q;
  localparam int W = B + R;
  localparam int IW = $clog2(W);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0;
  logic [Q-1:0] lookupModule = '0;
  logic faultValid = 1'b0;
  logic [IW-1:0] faultIndex = '0;
  logic selValid;
  logic [W-1:0] moduleSelect;
  logic refError;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // behavioural reference model
  int refMod[W];
  bit refValid[W];
  int refFree;

  always #2.5 clk = ~clk;

  module_remap_cam #(.MOD_BITS(Q), .SPARES(R)) u0 (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupModule(lookupModule),
    .faultValid(faultValid), .faultIndex(faultIndex), .selValid(selValid),
    .moduleSelect(moduleSelect), .refError(refError));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare at the following negedge
  task automatic step(input bit lv, input int lm, input bit fv, input int fi, input string tag);
    int expSel = 0;
    bit expErr = 0;
    if (lv) begin
      for (int i = 0; i < W; i++)
        if (refValid[i] && refMod[i] == lm) expSel = 1 << i;
      expErr = (expSel == 0);
    end
    if (fv && fi < W && refValid[fi]) begin
      refValid[fi] = 0;
      if (refFree > 0) begin
        refMod[B + R - refFree] = refMod[fi];
        refValid[B + R - refFree] = 1;
        refFree--;
      end
    end
    lookupValid  = lv;
    lookupModule = Q'(lm);
    faultValid   = fv;
    faultIndex   = IW'(fi);
    @(posedge clk);
    @(negedge clk);
    lookupValid = 0;
    faultValid  = 0;
    chk(tag, "moduleSelect", int'(moduleSelect), expSel);
    chk(tag, "selValid", int'(selValid), int'(lv));
    chk(tag, "refError", int'(refError), int'(expErr));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < W; i++) begin
      refMod[i] = (i < B) ? i : 0;
      refValid[i] = (i < B);
    end
    refFree = R;
    repeat (3) @(negedge clk);
    chk("R1", "reset select", int'(moduleSelect), 0);
    chk("R1", "reset selValid", int'(selValid), 0);
    chk("R1", "reset error", int'(refError), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1 identity map, R2 latency and idle
    for (int m = 0; m < B; m++) step(1, m, 0, 0, "R1");
    step(0, 0, 0, 0, "R2");
    step(1, 3, 0, 0, "R2");
    step(0, 2, 0, 0, "R2");
    // R8 request and fault together: old table answers
    step(1, 1, 1, 1, "R8");
    // R3 relocated module now on first spare
    step(1, 1, 0, 0, "R3");
    step(1, 0, 0, 0, "R3");
    // R6 dead entry and out-of-range index ignored
    step(0, 0, 1, 1, "R6");
    step(0, 0, 1, 7, "R6");
    step(1, 1, 0, 0, "R6");
    // R5 retire the spare serving module 1; R4 next spare used
    step(0, 0, 1, B, "R5");
    step(1, 1, 0, 0, "R5");
    step(1, 1, 0, 0, "R4");
    // R7 spares exhausted
    step(0, 0, 1, 2, "R7");
    step(1, 2, 0, 0, "R7");
    step(0, 0, 0, 0, "R7");
    step(1, 0, 0, 0, "R7");
    step(0, 0, 1, B + 1, "R7");
    step(1, 1, 0, 0, "R7");
    step(1, 3, 0, 0, "R9");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule